// File: doc/BRIEF.md
# Sync-Gated Receive FIFO

This block collects a demodulated serial bit stream into bytes. Each received bit comes with a one-cycle strobe from the clock-recovery logic upstream. Capture does not begin as soon as the block is enabled. It waits for a start condition picked by configuration: the data-valid indicator, a detected 16-bit sync pattern, both at the same moment, or no condition at all. Once capture has started, the incoming bits are packed most-significant-first into bytes. A small byte store holds them until software pops them with a read strobe.

A level field sets how many stored bits raise the interrupt. An active-low interrupt request and an active-high level flag both report that the level has been reached. Software then reads bytes. To accept the next packet it clears the fill enable, which flushes the store and re-arms the start logic, and then sets the fill enable again. The store holds 16 bits. Any bit that arrives when the store is full is discarded, and a sticky overflow flag records the loss.

Top module: `rx_sync_fifo`

## Requirements
- R1: The configuration byte is laid out as level in [7:4], start select in [3:2], fill enable in [1] and store enable in [0]. Reset loads 0x85, which means level 8, sync start, fill off and store on, so no bit is captured after reset until a configuration write sets the fill enable.
- R2: With start select 01, the block compares the last 16 strobed bits, first bit as MSB, against 0x2DD4. The bits before the match and the sync bits themselves are not stored. Bits strobed after the match are stored.
- R3: With start select 00, capture begins after the data-valid input has been seen high. Bits strobed while it is low before that point are not stored.
- R4: With start select 10, capture begins only when a sync match and a high data-valid input occur on the same strobe. With start select 11, capture begins one cycle after the block is armed.
- R5: Stored bits fill each byte from bit 7 down to bit 0. Bytes are read out in the order they were received. A read strobe honoured in one cycle produces rd_valid high together with the byte in the next cycle.
- R6: When the level is nonzero and the stored bit count is at least the level, lvl_out is 1 and irq_n is 0, one cycle after the count changes. Otherwise lvl_out is 0 and irq_n is 1. With level 1, lvl_out therefore shows that the store is not empty.
- R7: Capture requires both the fill enable and the store enable. Once capture has started it stays on across packets. Clearing either enable empties the store and clears the overflow flag, and after that a new start condition is needed.
- R8: The store holds 16 bits. A bit that arrives while the store is full and no byte is being read is dropped, and overflow goes high and stays high until the next flush.
- R9: A read strobe while fewer than 8 bits are stored is ignored: rd_valid stays 0 and nothing is removed.
- R10: When a bit arrives in the same cycle as an honoured read of a full store, the bit is accepted and overflow is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte (level, start select, fill, enable) |
| vdi | input | 1 | Data-valid indicator from the demodulator |
| bit_stb | input | 1 | One-cycle strobe marking a recovered bit |
| bit_in | input | 1 | Recovered data bit |
| rd_en | input | 1 | Byte read strobe |
| rd_data | output | 8 | Byte read out |
| rd_valid | output | 1 | rd_data holds a newly read byte |
| irq_n | output | 1 | Level-reached interrupt, active low |
| lvl_out | output | 1 | Level-reached flag, active high |
| overflow | output | 1 | Sticky flag for a dropped bit |

## Verification
A bit write and a byte read can happen in the same clock cycle. The case that matters is when the store is exactly full. The bench fills the store with 16 bits and then, in a single cycle, drives a bit strobe and a read strobe together. It expects the oldest byte on the read port with overflow still low. It then adds seven more bits and checks that the next two bytes read back contain the bit accepted in that shared cycle, in its correct position.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

  typedef enum logic [1:0] {
    START_VDI  = 2'b00,
    START_SYNC = 2'b01,
    START_BOTH = 2'b10,
    START_NOW  = 2'b11
  } start_sel_e;

  typedef struct packed {
    logic [3:0] level;
    start_sel_e sel;
    logic       fill;
    logic       enable;
  } rsf_cfg_t;

  localparam logic [7:0] CFG_RESET = 8'h85;

endpackage

// File: rtl/rsf_sync_det.sv
module rsf_sync_det #(
  parameter int          SYNC_W  = 16,
  parameter logic [15:0] PATTERN = 16'h2DD4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic shift,
  input  logic bit_in,
  output logic hit
);

  logic [SYNC_W-1:0] sr;
  logic [SYNC_W-1:0] window;

  // the window includes the bit on the current strobe, so a match is seen on that strobe
  assign window = {sr[SYNC_W-2:0], bit_in};
  assign hit    = shift && (window == PATTERN[SYNC_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sr <= '0;
    end else if (shift) begin
      sr <= window;
    end
  end

endmodule

// File: rtl/rsf_start_ctl.sv
module rsf_start_ctl
  import rsf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       arm,
  input  start_sel_e sel,
  input  logic       vdi,
  input  logic       sync_hit,
  output logic       started
);

  logic cond;

  always_comb begin
    unique case (sel)
      START_VDI:  cond = vdi;
      START_SYNC: cond = sync_hit;
      START_BOTH: cond = vdi && sync_hit;
      default:    cond = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      started <= 1'b0;
    end else if (cond) begin
      started <= 1'b1;
    end
  end

endmodule

// File: rtl/rsf_byte_store.sv
module rsf_byte_store #(
  parameter  int BYTE_W    = 8,
  parameter  int NUM_BYTES = 2,
  localparam int DEPTH     = BYTE_W * NUM_BYTES,
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int PTR_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int IDX_W     = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic              push_bit,
  input  logic              pop_req,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              ovf
);

  logic [BYTE_W-1:0] mem [NUM_BYTES];
  logic [BYTE_W-1:0] acc;
  logic [IDX_W-1:0]  acc_fill;
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;
  logic              pop;
  logic              room;
  logic              push_ok;
  logic              byte_done;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(NUM_BYTES - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop       = pop_req && (bit_cnt >= CNT_W'(BYTE_W)) && !flush;
  assign room      = (bit_cnt < CNT_W'(DEPTH)) || pop;
  assign push_ok   = push && room && !flush;
  assign byte_done = push_ok && (acc_fill == IDX_W'(BYTE_W - 1));

  // byte-wide memory with a registered read port
  always_ff @(posedge clk) begin
    if (byte_done) begin
      mem[wr_ptr] <= {acc[BYTE_W-2:0], push_bit};
    end
    if (pop) begin
      rd_data <= mem[rd_ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      acc      <= '0;
      acc_fill <= '0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      bit_cnt  <= '0;
      ovf      <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= pop;
      if (push_ok) begin
        acc <= {acc[BYTE_W-2:0], push_bit};
        if (byte_done) begin
          acc_fill <= '0;
          wr_ptr   <= ptr_inc(wr_ptr);
        end else begin
          acc_fill <= acc_fill + 1'b1;
        end
      end
      if (pop) begin
        rd_ptr <= ptr_inc(rd_ptr);
      end
      bit_cnt <= bit_cnt + CNT_W'(push_ok) - (pop ? CNT_W'(BYTE_W) : CNT_W'(0));
      if (push && !room) begin
        ovf <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rx_sync_fifo.sv
module rx_sync_fifo
  import rsf_pkg::*;
#(
  parameter  int          BYTE_W       = 8,
  parameter  int          NUM_BYTES    = 2,
  parameter  int          SYNC_W       = 16,
  parameter  logic [15:0] SYNC_PATTERN = 16'h2DD4,
  localparam int          DEPTH_BITS   = BYTE_W * NUM_BYTES,
  localparam int          CNT_W        = $clog2(DEPTH_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  input  logic              vdi,
  input  logic              bit_stb,
  input  logic              bit_in,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              irq_n,
  output logic              lvl_out,
  output logic              overflow
);

  rsf_cfg_t         cfg_q;
  logic             arm;
  logic             started;
  logic             sync_hit;
  logic [CNT_W-1:0] bit_cnt;
  logic             at_level;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= rsf_cfg_t'(CFG_RESET);
    end else if (cfg_wr) begin
      cfg_q <= rsf_cfg_t'(cfg_wdata);
    end
  end

  assign arm = cfg_q.fill && cfg_q.enable;

  rsf_sync_det #(
    .SYNC_W  (SYNC_W),
    .PATTERN (SYNC_PATTERN)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .clear  (!arm || started),
    .shift  (bit_stb && arm && !started),
    .bit_in (bit_in),
    .hit    (sync_hit)
  );

  rsf_start_ctl u_start (
    .clk      (clk),
    .rst      (rst),
    .arm      (arm),
    .sel      (cfg_q.sel),
    .vdi      (vdi),
    .sync_hit (sync_hit),
    .started  (started)
  );

  rsf_byte_store #(
    .BYTE_W    (BYTE_W),
    .NUM_BYTES (NUM_BYTES)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .flush    (!arm),
    .push     (bit_stb && started),
    .push_bit (bit_in),
    .pop_req  (rd_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .bit_cnt  (bit_cnt),
    .ovf      (overflow)
  );

  assign at_level = (cfg_q.level != 4'd0) && (bit_cnt >= CNT_W'(cfg_q.level));

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_out <= 1'b0;
      irq_n   <= 1'b1;
    end else begin
      lvl_out <= at_level;
      irq_n   <= !at_level;
    end
  end

endmodule

// File: rtl/rsf_checker.sv
module rsf_checker #(
  parameter int CNT_W = 5,
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       cfg_q,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             lvl_out,
  input logic             irq_n,
  input logic             ovf,
  input logic             rd_en,
  input logic             rd_valid
);

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    !(cfg_q[1] && cfg_q[0]) |=> (bit_cnt == '0) && !ovf); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && cfg_q[1] && cfg_q[0]) |=> ovf); // R8

  AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> ($past(bit_cnt) == CNT_W'(DEPTH))); // R8

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(DEPTH)); // R8

  AST_READ_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(rd_en) && ($past(bit_cnt) >= CNT_W'(8)))); // R9

  AST_LEVEL_REACHED: assert property (@(posedge clk) disable iff (rst)
    lvl_out |-> (($past(cfg_q[7:4]) != 4'd0) &&
                 ($past(bit_cnt) >= CNT_W'($past(cfg_q[7:4]))))); // R6

  AST_IRQ_LOW_MEANS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> ($past(bit_cnt) != '0)); // R6

endmodule

bind rx_sync_fifo rsf_checker #(
  .CNT_W (CNT_W),
  .DEPTH (DEPTH_BITS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_q    (cfg_q),
  .bit_cnt  (bit_cnt),
  .lvl_out  (lvl_out),
  .irq_n    (irq_n),
  .ovf      (overflow),
  .rd_en    (rd_en),
  .rd_valid (rd_valid)
);

// File: tb/rx_sync_fifo_bench.sv
module rx_sync_fifo_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       vdi = 1'b0;
  logic       bit_stb = 1'b0;
  logic       bit_in = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic       irq_n;
  logic       lvl_out;
  logic       overflow;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  rx_sync_fifo u_rx_sync_fifo (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .vdi       (vdi),
    .bit_stb   (bit_stb),
    .bit_in    (bit_in),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .irq_n     (irq_n),
    .lvl_out   (lvl_out),
    .overflow  (overflow)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [3:0] lvl, input logic [1:0] sel, input logic fill, input logic en);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_wdata = {lvl, sel, fill, en};
    @(negedge clk);
    cfg_wr = 1'b0;
    idle(2);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_stb = 1'b1;
    bit_in  = b;
    @(negedge clk);
    bit_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_sync();
    send_byte(8'h2D);
    send_byte(8'hD4);
  endtask

  // pulse rd_en for one cycle; returns the sampled valid flag and data
  task automatic read_byte(output logic v, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_valid;
    d = rd_data;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic v; logic [7:0] d;
    check("R1 irq_n after reset", irq_n, 1'b1);
    check("R1 lvl_out after reset", lvl_out, 1'b0);
    check("R1 overflow after reset", overflow, 1'b0);
    check("R1 rd_valid after reset", rd_valid, 1'b0);
    // reset config has fill off: a full sync plus payload must not be stored
    send_sync();
    send_byte(8'hF0);
    check("R1 no capture with reset config", lvl_out, 1'b0);
    read_byte(v, d);
    check("R1 read after reset config", v, 1'b0);
  endtask

  task automatic t_sync_start();
    logic v; logic [7:0] d;
    wr_cfg(4'd8, 2'b01, 1'b1, 1'b1);
    send_byte(8'hFF);
    send_sync();
    check("R2 sync bits not stored", lvl_out, 1'b0);
    for (int i = 7; i >= 1; i--) send_bit(d_a5(i));
    check("R6 seven bits below level", lvl_out, 1'b0);
    check("R6 irq_n high below level", irq_n, 1'b1);
    send_bit(1'b1);
    check("R6 lvl_out at level 8", lvl_out, 1'b1);
    check("R6 irq_n low at level 8", irq_n, 1'b0);
    read_byte(v, d);
    check("R5 rd_valid after read", v, 1'b1);
    check("R2 byte after sync", d, 8'hA5);
    idle(1);
    check("R6 level cleared after read", lvl_out, 1'b0);
  endtask

  function automatic logic d_a5(input int i);
    logic [7:0] p = 8'hA5;
    return p[i];
  endfunction

  task automatic t_rearm();
    logic v; logic [7:0] d;
    send_byte(8'h5A);
    read_byte(v, d);
    check("R7 capture persists without re-arm", d, 8'h5A);
    wr_cfg(4'd8, 2'b01, 1'b0, 1'b1);
    wr_cfg(4'd8, 2'b01, 1'b1, 1'b1);
    send_byte(8'h11);
    check("R7 re-armed waits for sync", lvl_out, 1'b0);
    read_byte(v, d);
    check("R7 nothing to read before sync", v, 1'b0);
    send_sync();
    send_byte(8'h77);
    read_byte(v, d);
    check("R7 byte after new sync", d, 8'h77);
  endtask

  task automatic t_vdi_start();
    logic v; logic [7:0] d;
    wr_cfg(4'd8, 2'b01, 1'b0, 1'b1);
    wr_cfg(4'd1, 2'b00, 1'b1, 1'b1);
    vdi = 1'b0;
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    check("R3 bits before vdi ignored", lvl_out, 1'b0);
    vdi = 1'b1;
    idle(2);
    send_bit(1'b0);
    check("R6 level 1 shows not-empty", lvl_out, 1'b1);
    for (int i = 6; i >= 0; i--) send_bit(i inside {5, 4, 3, 2});
    read_byte(v, d);
    check("R3 byte after vdi", d, 8'h3C);
    idle(1);
    check("R6 level 1 empty after read", lvl_out, 1'b0);
    vdi = 1'b0;
  endtask

  task automatic t_both_start();
    logic v; logic [7:0] d;
    wr_cfg(4'd8, 2'b01, 1'b0, 1'b1);
    wr_cfg(4'd8, 2'b10, 1'b1, 1'b1);
    send_sync();
    send_byte(8'hC3);
    check("R4 sync without vdi does not start", lvl_out, 1'b0);
    wr_cfg(4'd8, 2'b10, 1'b0, 1'b1);
    wr_cfg(4'd8, 2'b10, 1'b1, 1'b1);
    vdi = 1'b1;
    send_sync();
    send_byte(8'hC3);
    check("R4 sync with vdi starts", lvl_out, 1'b1);
    read_byte(v, d);
    check("R4 byte after sync and vdi", d, 8'hC3);
    vdi = 1'b0;
  endtask

  task automatic t_overflow();
    logic v; logic [7:0] d;
    wr_cfg(4'd8, 2'b10, 1'b0, 1'b1);
    wr_cfg(4'd15, 2'b11, 1'b1, 1'b1);
    send_byte(8'hDE);
    for (int i = 7; i >= 2; i--) send_bit(i inside {7, 5, 3, 2});
    check("R6 fourteen bits below level 15", lvl_out, 1'b0);
    send_bit(1'b0);
    check("R4 immediate start reaches level 15", lvl_out, 1'b1);
    send_bit(1'b1);
    check("R8 no overflow at exactly full", overflow, 1'b0);
    send_bit(1'b1);
    check("R8 overflow on extra bit", overflow, 1'b1);
    read_byte(v, d);
    check("R5 first byte in order", d, 8'hDE);
    read_byte(v, d);
    check("R8 newest bit dropped", d, 8'hAD);
    read_byte(v, d);
    check("R9 read of empty store ignored", v, 1'b0);
    check("R8 overflow sticky", overflow, 1'b1);
    wr_cfg(4'd15, 2'b11, 1'b0, 1'b1);
    check("R8 flush clears overflow", overflow, 1'b0);
  endtask

  task automatic t_simultaneous();
    logic v; logic [7:0] d;
    wr_cfg(4'd15, 2'b11, 1'b1, 1'b1);
    send_byte(8'h12);
    send_byte(8'h34);
    @(negedge clk);
    bit_stb = 1'b1;
    bit_in  = 1'b1;
    rd_en   = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    rd_en   = 1'b0;
    check("R10 read while full returns oldest", rd_data, 8'h12);
    check("R10 valid on shared cycle", rd_valid, 1'b1);
    idle(1);
    check("R10 no overflow on shared cycle", overflow, 1'b0);
    for (int i = 6; i >= 0; i--) send_bit(i[0] == 1'b1);
    read_byte(v, d);
    check("R10 second byte", d, 8'h34);
    read_byte(v, d);
    check("R10 byte holding shared-cycle bit", d, 8'hAA);
    read_byte(v, d);
    check("R9 read with nothing stored", v, 1'b0);
  endtask

  task automatic t_disabled();
    logic v; logic [7:0] d;
    wr_cfg(4'd1, 2'b11, 1'b1, 1'b0);
    send_byte(8'hFF);
    check("R7 store disabled ignores bits", lvl_out, 1'b0);
    read_byte(v, d);
    check("R7 store disabled read", v, 1'b0);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_sync_start();
    t_rearm();
    t_vdi_start();
    t_both_start();
    t_overflow();
    t_simultaneous();
    t_disabled();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule